// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block sits on the host side of an 8-bit multiplexed NAND flash bus. A host asks it for one of four transfers: a single command byte, a full address, a burst of write data or a burst of read data. The block then drives the chip-enable, command-latch, address-latch, write-strobe and read-strobe lines and the direction of the shared I/O bus. Every strobe phase lasts a whole number of system clock cycles, and each of these counts is a parameter.

Two gates hold back the start of a new request. The first is the device's ready/busy line, which passes through a synchronizer. The second is a guard window that begins after every command byte, so the device has time to pull the line low. The block also drives the device's write-protect pin. That pin changes only while the engine is idle, and no request that writes may start until a set number of cycles after the pin last moved. An address transfer always has five bytes: two column bytes and then three row bytes, low-order byte first, with the unused upper bits set to zero.

Top module: `nand_cycle_engine`

## Requirements
- R1: After reset, nand_ce_n, nand_we_n and nand_re_n are 1; nand_cle, nand_ale, nand_io_oe and nand_wp_n are 0; and no pulse output is active.
- R2: A command request (req_op=0) drives nand_cle=1 and nand_ale=0 with req_cmd on nand_io_out for exactly one write-strobe pulse.
- R3: An address request (req_op=1) sends five bytes with nand_ale=1 and nand_cle=0, in this order: col[7:0], {4'b0,col[11:8]}, row[7:0], row[15:8], {7'b0,row[16]}.
- R4: Each write-strobe pulse holds nand_we_n low for WE_LO cycles and then high for WE_HI cycles. CLE, ALE and the data byte are set at the falling edge of the strobe and stay unchanged until its high phase ends.
- R5: A write burst (req_op=2) sends req_len+1 bytes taken from wr_data. wr_pop pulses for one cycle in the cycle each byte goes onto the bus, and the host then presents the next byte.
- R6: A read burst (req_op=3) releases the bus (nand_io_oe=0) and makes req_len+1 read pulses, each low for RE_LO cycles and high for RE_HI cycles. nand_io_in is captured at the edge where nand_re_n rises, and rd_valid pulses with that byte in the first cycle that nand_re_n is high.
- R7: req_ack pulses in the cycle after a request is accepted, and nand_ce_n falls in that same cycle. req_done pulses in the cycle after the last strobe phase ends, with nand_ce_n=1, nand_cle=0, nand_ale=0 and nand_io_oe=0.
- R8: A request is not accepted while the synchronized ready/busy input (SYNC_STAGES flops) is low.
- R9: After a command byte completes, no request is accepted for BUSY_GAP cycles.
- R10: nand_wp_n takes the value of host_wp_n only while the engine is idle. Write-type requests (req_op 0, 1 or 2) wait until WP_GAP cycles have passed since nand_wp_n changed; read requests do not wait.
- R11: nand_cle and nand_ale are never high together, and nand_we_n and nand_re_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pending; held until req_ack |
| req_op | input | 2 | 0 command, 1 address, 2 write burst, 3 read burst |
| req_len | input | LEN_W | Burst length minus one |
| req_cmd | input | 8 | Command byte |
| req_col | input | COL_W | Column address |
| req_row | input | ROW_W | Row address (block and page) |
| req_ack | output | 1 | Request accepted pulse |
| req_done | output | 1 | Request finished pulse |
| wr_data | input | 8 | Current write-burst byte |
| wr_pop | output | 1 | Current write byte consumed |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | rd_data valid pulse |
| host_wp_n | input | 1 | Requested write-protect level |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_rb | input | 1 | Ready/busy, low means busy (asynchronous) |
| nand_io_out | output | 8 | Bus data driven to the device |
| nand_io_oe | output | 1 | Bus drive enable |
| nand_io_in | input | 8 | Bus data from the device |

## Verification
Every output is registered, so a wrong phase counter or a wrong remaining-byte count shows up at the strobe pins in the next cycle. It appears as a pulse that is too short or too long, an extra byte, or a missing byte. A wrong address shift or a wrong data-source choice shows up as a wrong byte on nand_io_out during the first strobe that uses it. Errors in the guard and write-protect timers are less direct: they show only as a req_ack that arrives too early or too late relative to the ready/busy or write-protect change that should have held the request back. The reference model predicts the exact cycle of each acknowledge, so one cycle of error is enough to show.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_ADDR  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } nand_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WLO,
    ST_WHI,
    ST_RLO,
    ST_RHI
  } seq_state_e;

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rb_async,
  output logic rb_ready
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= rb_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], rb_async};
      end
    end
  endgenerate

  assign rb_ready = sync_q[STAGES-1];
endmodule

// File: rtl/nand_gap_timer.sv
module nand_gap_timer #(
  parameter int W   = 8,
  parameter int VAL = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic clear
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= W'(VAL);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign clear = (cnt_q == '0);
endmodule

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine
  import nand_seq_pkg::*;
#(
  parameter int COL_W       = 12,
  parameter int ROW_W       = 17,
  parameter int LEN_W       = 12,
  parameter int CNT_W       = 4,
  parameter int WE_LO       = 3,
  parameter int WE_HI       = 2,
  parameter int RE_LO       = 3,
  parameter int RE_HI       = 2,
  parameter int GAP_W       = 8,
  parameter int WP_GAP      = 10,
  parameter int BUSY_GAP    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       req_cmd,
  input  logic [COL_W-1:0] req_col,
  input  logic [ROW_W-1:0] req_row,
  output logic             req_ack,
  output logic             req_done,
  input  logic [7:0]       wr_data,
  output logic             wr_pop,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             host_wp_n,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic             nand_wp_n,
  input  logic             nand_rb,
  output logic [7:0]       nand_io_out,
  output logic             nand_io_oe,
  input  logic [7:0]       nand_io_in
);
  localparam int COL_BYTES  = (COL_W + 7) / 8;
  localparam int ROW_BYTES  = (ROW_W + 7) / 8;
  localparam int ADDR_BYTES = COL_BYTES + ROW_BYTES;
  localparam int ADDR_BITS  = 8 * ADDR_BYTES;

  seq_state_e             state;
  nand_op_e               op_q;
  nand_op_e               op_in;
  logic [CNT_W-1:0]       ph_cnt;
  logic [LEN_W-1:0]       remain;
  logic [ADDR_BITS-1:0]   addr_full;
  logic [ADDR_BITS-1:0]   addr_sh;
  logic                   rb_ok;
  logic                   guard_clear;
  logic                   wpgap_clear;
  logic                   idle;
  logic                   wp_load;
  logic                   accept;
  logic                   guard_load;

  assign op_in = nand_op_e'(req_op);
  assign idle  = (state == ST_IDLE);

  // column bytes first, then row bytes; unused upper bits stay zero
  always_comb begin
    addr_full = '0;
    addr_full[COL_W-1:0] = req_col;
    addr_full[8*COL_BYTES +: ROW_W] = req_row;
  end

  assign wp_load    = idle && (host_wp_n != nand_wp_n);
  assign accept     = idle && req_valid && rb_ok && guard_clear && !wp_load &&
                      ((op_in == OP_READ) || wpgap_clear);
  assign guard_load = (state == ST_WHI) && (ph_cnt == '0) && (remain == '0) &&
                      (op_q == OP_CMD);

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
    .clk      (clk),
    .rst      (rst),
    .rb_async (nand_rb),
    .rb_ready (rb_ok)
  );

  nand_gap_timer #(.W(GAP_W), .VAL(BUSY_GAP)) u_busy_guard (
    .clk   (clk),
    .rst   (rst),
    .load  (guard_load),
    .clear (guard_clear)
  );

  nand_gap_timer #(.W(GAP_W), .VAL(WP_GAP)) u_wp_guard (
    .clk   (clk),
    .rst   (rst),
    .load  (wp_load),
    .clear (wpgap_clear)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      op_q        <= OP_CMD;
      ph_cnt      <= '0;
      remain      <= '0;
      addr_sh     <= '0;
      nand_ce_n   <= 1'b1;
      nand_cle    <= 1'b0;
      nand_ale    <= 1'b0;
      nand_we_n   <= 1'b1;
      nand_re_n   <= 1'b1;
      nand_wp_n   <= 1'b0;
      nand_io_oe  <= 1'b0;
      nand_io_out <= '0;
      req_ack     <= 1'b0;
      req_done    <= 1'b0;
      wr_pop      <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      req_ack  <= 1'b0;
      req_done <= 1'b0;
      wr_pop   <= 1'b0;
      rd_valid <= 1'b0;
      if (wp_load) nand_wp_n <= host_wp_n;

      case (state)
        ST_IDLE: begin
          if (accept) begin
            req_ack   <= 1'b1;
            nand_ce_n <= 1'b0;
            op_q      <= op_in;
            case (op_in)
              OP_CMD: begin
                nand_cle    <= 1'b1;
                nand_io_out <= req_cmd;
                remain      <= '0;
              end
              OP_ADDR: begin
                nand_ale    <= 1'b1;
                nand_io_out <= addr_full[7:0];
                addr_sh     <= addr_full >> 8;
                remain      <= LEN_W'(ADDR_BYTES - 1);
              end
              OP_WRITE: begin
                nand_io_out <= wr_data;
                wr_pop      <= 1'b1;
                remain      <= req_len;
              end
              default: begin
                remain      <= req_len;
              end
            endcase
            if (op_in == OP_READ) begin
              nand_re_n <= 1'b0;
              ph_cnt    <= CNT_W'(RE_LO - 1);
              state     <= ST_RLO;
            end else begin
              nand_io_oe <= 1'b1;
              nand_we_n  <= 1'b0;
              ph_cnt     <= CNT_W'(WE_LO - 1);
              state      <= ST_WLO;
            end
          end
        end

        ST_WLO: begin
          if (ph_cnt == '0) begin
            nand_we_n <= 1'b1;
            ph_cnt    <= CNT_W'(WE_HI - 1);
            state     <= ST_WHI;
          end else begin
            ph_cnt <= ph_cnt - 1'b1;
          end
        end

        ST_WHI: begin
          if (ph_cnt != '0) begin
            ph_cnt <= ph_cnt - 1'b1;
          end else if (remain == '0) begin
            nand_ce_n  <= 1'b1;
            nand_cle   <= 1'b0;
            nand_ale   <= 1'b0;
            nand_io_oe <= 1'b0;
            req_done   <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            remain    <= remain - 1'b1;
            nand_we_n <= 1'b0;
            ph_cnt    <= CNT_W'(WE_LO - 1);
            state     <= ST_WLO;
            if (op_q == OP_ADDR) begin
              nand_io_out <= addr_sh[7:0];
              addr_sh     <= addr_sh >> 8;
            end else if (op_q == OP_WRITE) begin
              nand_io_out <= wr_data;
              wr_pop      <= 1'b1;
            end
          end
        end

        ST_RLO: begin
          if (ph_cnt == '0) begin
            nand_re_n <= 1'b1;
            rd_data   <= nand_io_in;
            rd_valid  <= 1'b1;
            ph_cnt    <= CNT_W'(RE_HI - 1);
            state     <= ST_RHI;
          end else begin
            ph_cnt <= ph_cnt - 1'b1;
          end
        end

        ST_RHI: begin
          if (ph_cnt != '0) begin
            ph_cnt <= ph_cnt - 1'b1;
          end else if (remain == '0) begin
            nand_ce_n <= 1'b1;
            req_done  <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            remain    <= remain - 1'b1;
            nand_re_n <= 1'b0;
            ph_cnt    <= CNT_W'(RE_LO - 1);
            state     <= ST_RLO;
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_cycle_engine_chk.sv
module nand_cycle_engine_chk #(
  parameter int WE_LO  = 3,
  parameter int RE_LO  = 3,
  parameter int WP_GAP = 10
) (
  input logic clk,
  input logic rst,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_io_oe,
  input logic nand_wp_n,
  input logic req_done,
  input logic rd_valid,
  input logic rb_ok
);
  logic [7:0] we_lo_cnt;
  logic [7:0] re_lo_cnt;
  logic [7:0] since_wp;
  logic       wp_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo_cnt <= '0;
      re_lo_cnt <= '0;
      since_wp  <= '1;
      wp_prev   <= 1'b0;
    end else begin
      we_lo_cnt <= nand_we_n ? 8'd0 : ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1);
      re_lo_cnt <= nand_re_n ? 8'd0 : ((re_lo_cnt == 8'hFF) ? re_lo_cnt : re_lo_cnt + 8'd1);
      wp_prev   <= nand_wp_n;
      if (nand_wp_n != wp_prev)  since_wp <= 8'd1;
      else if (since_wp != 8'hFF) since_wp <= since_wp + 8'd1;
    end
  end

  assert_latch_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));
  assert_we_width_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(nand_we_n) |-> (we_lo_cnt >= 8'(WE_LO)));
  assert_latch_stable_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(nand_we_n) |-> ($stable(nand_cle) && $stable(nand_ale)));
  assert_re_width_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(nand_re_n) |-> (re_lo_cnt >= 8'(RE_LO)));
  assert_read_capture_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($rose(nand_re_n) && !nand_io_oe));
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    req_done |-> (nand_ce_n && !nand_io_oe && nand_we_n && nand_re_n));
  assert_start_ready_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(nand_ce_n) |-> $past(rb_ok));
  assert_wp_gap_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(nand_we_n) |-> (since_wp >= 8'(WP_GAP)));
endmodule

bind nand_cycle_engine nand_cycle_engine_chk #(
  .WE_LO  (WE_LO),
  .RE_LO  (RE_LO),
  .WP_GAP (WP_GAP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .nand_ce_n  (nand_ce_n),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_io_oe (nand_io_oe),
  .nand_wp_n  (nand_wp_n),
  .req_done   (req_done),
  .rd_valid   (rd_valid),
  .rb_ok      (rb_ok)
);

// File: tb/test_nand_cycle_engine.sv
module test_nand_cycle_engine;
  localparam int WE_LO = 3, WE_HI = 2, RE_LO = 3, RE_HI = 2;
  localparam int WP_GAP = 10, BUSY_GAP = 10;

  typedef struct packed {
    logic [7:0] tag;
    logic ce_n, cle, ale, we_n, re_n, oe, ack, done, rv, pop, wp, gset;
    logic [7:0] dout;
    logic [7:0] rdat;
  } vec_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [11:0] req_len = '0;
  logic [7:0]  req_cmd = '0;
  logic [11:0] req_col = '0;
  logic [16:0] req_row = '0;
  logic        host_wp_n = 1'b0;
  logic        nand_rb = 1'b0;
  logic        req_ack, req_done, wr_pop, rd_valid;
  logic [7:0]  rd_data, wr_data, nand_io_out, nand_io_in;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n, nand_io_oe;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int wr_ptr = 0, rd_ptr = 0;

  function automatic logic [7:0] wpat(int k); return 8'(k * 13 + 90); endfunction
  function automatic logic [7:0] rpat(int k); return 8'(k * 37 + 5);  endfunction

  assign wr_data    = wpat(wr_ptr);
  assign nand_io_in = rpat(rd_ptr);

  nand_cycle_engine i_nand_cycle_engine (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_len(req_len),
    .req_cmd(req_cmd), .req_col(req_col), .req_row(req_row), .req_ack(req_ack),
    .req_done(req_done), .wr_data(wr_data), .wr_pop(wr_pop), .rd_data(rd_data),
    .rd_valid(rd_valid), .host_wp_n(host_wp_n), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n), .nand_rb(nand_rb),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in)
  );

  // device side: next read byte after each read strobe rises; host side: next write byte after pop
  always @(posedge nand_re_n) rd_ptr++;
  always @(negedge clk) if (!rst && wr_pop) wr_ptr++;

  // ---------------- reference model ----------------
  vec_t q[$];
  vec_t exp_v;
  bit   m_s1, m_s2, m_wp, started;
  int   m_guard, m_gap;

  function automatic vec_t idle_v();
    vec_t v = '0;
    v.ce_n = 1'b1; v.we_n = 1'b1; v.re_n = 1'b1; v.tag = 8'd1;
    return v;
  endfunction

  task automatic push_wr(logic [7:0] b, bit c, bit a, bit p, bit first, int tag);
    vec_t v;
    for (int i = 0; i < WE_LO + WE_HI; i++) begin
      v = idle_v();
      v.tag = 8'(tag); v.ce_n = 1'b0; v.cle = c; v.ale = a; v.oe = 1'b1; v.dout = b;
      v.we_n = (i >= WE_LO);
      v.ack  = first && (i == 0);
      v.pop  = p && (i == 0);
      q.push_back(v);
    end
  endtask

  task automatic push_rd(logic [7:0] b, bit first);
    vec_t v;
    for (int i = 0; i < RE_LO + RE_HI; i++) begin
      v = idle_v();
      v.tag = 8'd6; v.ce_n = 1'b0;
      v.re_n = (i >= RE_LO);
      v.ack  = first && (i == 0);
      v.rv   = (i == RE_LO);
      v.rdat = b;
      q.push_back(v);
    end
  endtask

  task automatic build();
    vec_t d;
    logic [39:0] av;
    case (req_op)
      2'd0: push_wr(req_cmd, 1'b1, 1'b0, 1'b0, 1'b1, 2);
      2'd1: begin
        av = '0; av[11:0] = req_col; av[16 +: 17] = req_row;
        for (int k = 0; k < 5; k++) push_wr(av[8*k +: 8], 1'b0, 1'b1, 1'b0, k == 0, 3);
      end
      2'd2: for (int k = 0; k <= int'(req_len); k++) push_wr(wpat(wr_ptr + k), 1'b0, 1'b0, 1'b1, k == 0, 5);
      default: for (int k = 0; k <= int'(req_len); k++) push_rd(rpat(rd_ptr + k), k == 0);
    endcase
    d = idle_v(); d.done = 1'b1; d.tag = 8'd7; d.gset = (req_op == 2'd0);
    q.push_back(d);
  endtask

  always @(posedge clk) begin
    bit idle_now, wpchg;
    if (rst) begin
      q.delete(); m_s1 = 0; m_s2 = 0; m_wp = 0; m_guard = 0; m_gap = 0;
      exp_v = idle_v(); started = 1;
    end else begin
      idle_now = (q.size() == 0);
      wpchg    = idle_now && (host_wp_n != m_wp);
      if (idle_now && req_valid && m_s2 && m_guard == 0 && !wpchg &&
          (req_op == 2'd3 || m_gap == 0)) build();
      exp_v = (q.size() != 0) ? q.pop_front() : idle_v();
      if (exp_v.gset) m_guard = BUSY_GAP; else if (m_guard > 0) m_guard--;
      if (wpchg) begin m_wp = host_wp_n; m_gap = WP_GAP; end
      else if (m_gap > 0) m_gap--;
      m_s2 = m_s1; m_s1 = nand_rb;
      exp_v.wp = m_wp;
    end
  end

  // ---------------- cycle compare ----------------
  always @(negedge clk) begin
    logic [10:0] a, e;
    bit bad;
    if (started && !rst) begin
      a = {nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe,
           req_ack, req_done, rd_valid, wr_pop, nand_wp_n};
      e = {exp_v.ce_n, exp_v.cle, exp_v.ale, exp_v.we_n, exp_v.re_n, exp_v.oe,
           exp_v.ack, exp_v.done, exp_v.rv, exp_v.pop, exp_v.wp};
      bad = (a !== e) || (exp_v.oe && nand_io_out !== exp_v.dout) ||
            (exp_v.rv && rd_data !== exp_v.rdat);
      n_chk++;
      if (bad) begin
        n_bad++;
        $display("FAIL R%0d cycle %0d: actual pins=%h io=%h rd=%h expected pins=%h io=%h rd=%h",
                 exp_v.tag, cyc, a, nand_io_out, rd_data, e, exp_v.dout, exp_v.rdat);
      end
      n_chk++; // R11 exclusivity
      if ((nand_cle && nand_ale) || (!nand_we_n && !nand_re_n)) begin
        n_bad++;
        $display("FAIL R11 cycle %0d: actual cle/ale/we_n/re_n=%b%b%b%b expected no overlap",
                 cyc, nand_cle, nand_ale, nand_we_n, nand_re_n);
      end
    end
  end

  // ---------------- stimulus ----------------
  int ack_cyc, done_cyc;

  task automatic chk(bit ok, int r, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d: actual %0d expected %0d", r, act, expv);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [7:0] cmd, logic [11:0] col,
                       logic [16:0] row, logic [11:0] len);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_cmd = cmd; req_col = col; req_row = row; req_len = len;
    do @(negedge clk); while (!req_ack);
    ack_cyc = cyc;
    req_valid = 1'b0;
    do @(negedge clk); while (!req_done);
    done_cyc = cyc;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL R7 watchdog: actual no completion expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int acks, t0, d0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle levels after reset
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe && !nand_wp_n,
        1, {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe, nand_wp_n}, 7'b1110000);

    // R8: busy line low blocks the first request
    req_valid = 1'b1; req_op = 2'd0; req_cmd = 8'hFF;
    acks = 0;
    repeat (20) begin @(negedge clk); if (req_ack) acks++; end
    chk(acks == 0, 8, acks, 0);
    nand_rb = 1'b1; t0 = cyc;
    do @(negedge clk); while (!req_ack);
    req_valid = 1'b0;
    chk(cyc - t0 >= 2, 8, cyc - t0, 2);
    do @(negedge clk); while (!req_done);
    d0 = cyc;

    // R9 and R2: guard window after a command byte
    issue(2'd0, 8'h00, '0, '0, '0);
    chk(ack_cyc - d0 >= BUSY_GAP, 9, ack_cyc - d0, BUSY_GAP + 1);
    chk(ack_cyc - d0 <= BUSY_GAP + 2, 9, ack_cyc - d0, BUSY_GAP + 1);

    // R3: five address bytes
    issue(2'd1, 8'h00, 12'hABC, 17'h1F0E5, '0);
    issue(2'd1, 8'h00, 12'h801, 17'h00A3C, '0);

    // R8: device goes busy after a command, read waits for release
    issue(2'd0, 8'h30, '0, '0, '0);
    nand_rb = 1'b0;
    fork
      begin repeat (30) @(negedge clk); nand_rb = 1'b1; t0 = cyc; end
      issue(2'd3, 8'h00, '0, '0, 12'd3); // R6 four-byte read
    join
    chk(ack_cyc - t0 >= 2, 8, ack_cyc - t0, 3);

    // R5 write bursts, R6 single read
    issue(2'd2, 8'h00, '0, '0, 12'd7);
    issue(2'd3, 8'h00, '0, '0, 12'd0);
    issue(2'd2, 8'h00, '0, '0, 12'd0);

    // R10: write waits for write-protect gap
    @(negedge clk);
    host_wp_n = 1'b1; t0 = cyc;
    issue(2'd2, 8'h00, '0, '0, 12'd2);
    chk(ack_cyc - t0 >= WP_GAP, 10, ack_cyc - t0, WP_GAP + 2);
    chk(nand_wp_n == 1'b1, 10, nand_wp_n, 1);

    // R10: read is not held by the gap
    @(negedge clk);
    host_wp_n = 1'b0; t0 = cyc;
    issue(2'd3, 8'h00, '0, '0, 12'd1);
    chk(ack_cyc - t0 <= 3, 10, ack_cyc - t0, 2);
    chk(nand_wp_n == 1'b0, 10, nand_wp_n, 0);

    issue(2'd0, 8'h70, '0, '0, '0);
    repeat (5) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule